// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time on a valid/ready handshake. A request is either a single-byte program or a whole-chip erase. The block then drives the chip-enable, output-enable and write-enable strobes, the address bus and a separate data-out bus with its own output enable. It produces the unlock write cycles the device expects, and then the final command or data write.

After the last write the block reads the device over and over until the operation has finished. Two completion tests are available. The first compares the top data bit with the bit that was written. The second waits for bit 6 to hold its value across two reads in a row. Once completion is seen, one verification read compares the whole byte, and the block reports the result. A programmable limit on the number of poll reads ends a hung operation with a timeout. The width of the write-enable pulse is programmable in clock cycles, so the design can meet the device's minimum pulse width at any clock rate.

Top module: `fpc_top`

## Requirements
- R1: After reset, `req_ready` is 1, all three strobes are high, `flash_dq_oe` is 0 and `done_valid` is 0. `req_ready` is 1 only while no operation is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 again in the cycle after `done_valid`.
- R2: A program request (`req_erase`=0) issues exactly four write cycles, as (address, data) pairs in this order: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R3: An erase request (`req_erase`=1) issues exactly six write cycles in this order: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R4: In each write cycle, `flash_we_n` is low for exactly `cfg_we_clks` clocks, and a value of 0 counts as 1. Chip enable is low and output enable is high throughout. Address and data are driven one clock before write enable falls and do not change until one clock after it rises.
- R5: A read cycle has chip enable and output enable low, write enable high and `flash_dq_oe` 0. The clock before output enable falls always has write enable high and `flash_dq_oe` 0.
- R6: In data-poll mode (`req_toggle`=0), every poll read is at `req_addr`. Polling ends on the first read whose bit 7 equals bit 7 of the expected byte. The expected byte is `req_data` for a program and FFh for an erase.
- R7: In toggle mode (`req_toggle`=1), polling ends on the first read whose bit 6 equals bit 6 of the read before it, within the same operation.
- R8: After completion, one more read at `req_addr` takes place. `done_mismatch` is 1 if that byte differs from the expected byte, including when the request asked for a 0 bit to become 1.
- R9: If `cfg_poll_limit` poll reads (at least one) finish without showing completion, the block reports `done_timeout`=1 with no verification read. A read that both shows completion and is the last one allowed counts as a success.
- R10: `done_timeout` and `done_mismatch` are 0 in every cycle where `done_valid` is 0. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_erase | input | 1 | 1 = chip erase, 0 = byte program |
| req_toggle | input | 1 | 1 = toggle-bit polling, 0 = data polling |
| req_addr | input | ADDR_W | Target address (program) or check address (erase) |
| req_data | input | DATA_W | Byte to program |
| cfg_we_clks | input | WE_W | Write-enable low width in clocks |
| cfg_poll_limit | input | POLL_W | Maximum number of poll reads |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_addr | output | ADDR_W | Address bus |
| flash_dq_out | output | DATA_W | Data driven to the device |
| flash_dq_oe | output | 1 | Enable for the data-out drivers |
| flash_dq_in | input | DATA_W | Data read from the device |
| done_valid | output | 1 | One-cycle completion pulse |
| done_timeout | output | 1 | Poll limit reached |
| done_mismatch | output | 1 | Verification byte differed |

## Verification
Two decisions can fall on the same poll read. One is that the completion test succeeds. The other is that the poll budget runs out. The bench sets up this case with a device model that stays busy for exactly one read fewer than `cfg_poll_limit`, so completion first appears on the last permitted read. The outcome is judged by the reported flags, which must show a success with no timeout, and by the number of reads, which must include the extra verification read. Runs with the model permanently busy, in both polling modes, then show the opposite side of the rule: exactly `cfg_poll_limit` reads, a timeout, and no verification read.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_LOW, B_HOLD, B_GAP, B_READ
  } bus_st_t;

  typedef enum logic [2:0] {
    T_IDLE, T_CMD, T_CMDW, T_POLL, T_POLLW, T_VER, T_VERW, T_DONE
  } top_st_t;

  parameter logic [15:0] UNLK_ADDR_A = 16'h5555;
  parameter logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  parameter logic [7:0]  KEY_A       = 8'hAA;
  parameter logic [7:0]  KEY_B       = 8'h55;
  parameter logic [7:0]  OPC_PROG    = 8'hA0;
  parameter logic [7:0]  OPC_ERASE   = 8'h80;
  parameter logic [7:0]  OPC_ERS_GO  = 8'h10;

endpackage

// File: rtl/fpc_cmd.sv
module fpc_cmd #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              erase,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data,
  output logic              last
);
  import fpc_pkg::*;

  localparam logic [ADDR_W-1:0] AA = ADDR_W'(UNLK_ADDR_A);
  localparam logic [ADDR_W-1:0] AB = ADDR_W'(UNLK_ADDR_B);

  always_comb begin
    cyc_addr = AA;
    cyc_data = DATA_W'(KEY_A);
    unique case (step)
      3'd0: begin cyc_addr = AA; cyc_data = DATA_W'(KEY_A); end
      3'd1: begin cyc_addr = AB; cyc_data = DATA_W'(KEY_B); end
      3'd2: begin
        cyc_addr = AA;
        cyc_data = erase ? DATA_W'(OPC_ERASE) : DATA_W'(OPC_PROG);
      end
      3'd3: begin
        cyc_addr = erase ? AA : tgt_addr;
        cyc_data = erase ? DATA_W'(KEY_A) : tgt_data;
      end
      3'd4: begin cyc_addr = AB; cyc_data = DATA_W'(KEY_B); end
      3'd5: begin cyc_addr = AA; cyc_data = DATA_W'(OPC_ERS_GO); end
      default: begin cyc_addr = AA; cyc_data = DATA_W'(KEY_A); end
    endcase
    last = erase ? (step == 3'd5) : (step == 3'd3);
  end

endmodule

// File: rtl/fpc_bus.sv
module fpc_bus #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int WE_W    = 4,
  parameter int RD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WE_W-1:0]   we_clks,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  import fpc_pkg::*;

  localparam int RD_W  = $clog2(RD_CLKS + 1);
  localparam int CNT_W = (WE_W > RD_W) ? WE_W : RD_W;

  bus_st_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rdata_q;
  logic              done_q, done_n;
  logic              ld, cap;
  logic [WE_W-1:0]   we_eff;

  assign we_eff = (we_clks == '0) ? WE_W'(1) : we_clks;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    ld     = 1'b0;
    cap    = 1'b0;
    done_n = 1'b0;
    unique case (st_q)
      B_IDLE: if (start) begin
        ld   = 1'b1;
        st_n = rd ? B_GAP : B_SETUP;
      end
      B_SETUP: begin
        st_n  = B_LOW;
        cnt_n = CNT_W'(we_eff - WE_W'(1));
      end
      B_LOW: begin
        if (cnt_q == '0) st_n = B_HOLD;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      B_HOLD: begin
        st_n   = B_IDLE;
        done_n = 1'b1;
      end
      B_GAP: begin
        st_n  = B_READ;
        cnt_n = CNT_W'(RD_CLKS - 1);
      end
      B_READ: begin
        if (cnt_q == '0) begin
          st_n   = B_IDLE;
          cap    = 1'b1;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      default: st_n = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ld) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
      if (cap) rdata_q <= dq_in;
    end
  end

  assign ce_n   = !(st_q == B_SETUP || st_q == B_LOW || st_q == B_HOLD || st_q == B_READ);
  assign oe_n   = !(st_q == B_READ);
  assign we_n   = !(st_q == B_LOW);
  assign dq_oe  = (st_q == B_SETUP || st_q == B_LOW || st_q == B_HOLD);
  assign addr_o = addr_q;
  assign dq_out = data_q;
  assign done   = done_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/fpc_top.sv
module fpc_top #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int WE_W    = 4,
  parameter int POLL_W  = 16,
  parameter int RD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic              req_toggle,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [WE_W-1:0]   cfg_we_clks,
  input  logic [POLL_W-1:0] cfg_poll_limit,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_in,
  output logic              done_valid,
  output logic              done_timeout,
  output logic              done_mismatch
);
  import fpc_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = 6;

  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  top_st_t           st_q, st_n;
  logic              erase_q, tog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, exp_b;
  logic [2:0]        step_q, step_n;
  logic [POLL_W-1:0] polls_q, polls_n;
  logic              prev_q, prev_n, havep_q, havep_n;
  logic              tmo_q, tmo_n, mis_q, mis_n;
  logic              ld_req;
  logic [POLL_W:0]   polls_inc;
  logic              complete;

  logic              b_start, b_rd, b_done;
  logic [ADDR_W-1:0] b_addr, c_addr;
  logic [DATA_W-1:0] b_data, c_data, b_rdata;
  logic              c_last;

  assign exp_b     = erase_q ? '1 : data_q;
  assign polls_inc = {1'b0, polls_q} + (POLL_W+1)'(1);
  assign complete  = tog_q ? (havep_q && (b_rdata[TOG_BIT] == prev_q))
                           : (b_rdata[POLL_BIT] == exp_b[POLL_BIT]);

  fpc_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmd (
    .erase(erase_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .cyc_addr(c_addr), .cyc_data(c_data), .last(c_last)
  );

  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    polls_n = polls_q;
    prev_n  = prev_q;
    havep_n = havep_q;
    tmo_n   = tmo_q;
    mis_n   = mis_q;
    ld_req  = 1'b0;
    b_start = 1'b0;
    b_rd    = 1'b0;
    b_addr  = addr_q;
    b_data  = c_data;
    unique case (st_q)
      T_IDLE: if (req_valid) begin
        ld_req = 1'b1;
        step_n = 3'd0;
        tmo_n  = 1'b0;
        mis_n  = 1'b0;
        st_n   = T_CMD;
      end
      T_CMD: begin
        b_start = 1'b1;
        b_addr  = c_addr;
        st_n    = T_CMDW;
      end
      T_CMDW: if (b_done) begin
        if (c_last) begin
          polls_n = '0;
          havep_n = 1'b0;
          st_n    = T_POLL;
        end else begin
          step_n = step_q + 3'd1;
          st_n   = T_CMD;
        end
      end
      T_POLL: begin
        b_start = 1'b1;
        b_rd    = 1'b1;
        st_n    = T_POLLW;
      end
      T_POLLW: if (b_done) begin
        prev_n  = b_rdata[TOG_BIT];
        havep_n = 1'b1;
        if (complete) begin
          st_n = T_VER;
        end else if (polls_inc >= {1'b0, cfg_poll_limit}) begin
          tmo_n = 1'b1;
          st_n  = T_DONE;
        end else begin
          polls_n = polls_inc[POLL_W-1:0];
          st_n    = T_POLL;
        end
      end
      T_VER: begin
        b_start = 1'b1;
        b_rd    = 1'b1;
        st_n    = T_VERW;
      end
      T_VERW: if (b_done) begin
        mis_n = (b_rdata != exp_b);
        st_n  = T_DONE;
      end
      T_DONE: st_n = T_IDLE;
      default: st_n = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= T_IDLE;
      step_q  <= '0;
      polls_q <= '0;
      prev_q  <= 1'b0;
      havep_q <= 1'b0;
      tmo_q   <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      step_q  <= step_n;
      polls_q <= polls_n;
      prev_q  <= prev_n;
      havep_q <= havep_n;
      tmo_q   <= tmo_n;
      mis_q   <= mis_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      erase_q <= 1'b0;
      tog_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (ld_req) begin
      erase_q <= req_erase;
      tog_q   <= req_toggle;
      addr_q  <= req_addr;
      data_q  <= req_data;
    end
  end

  fpc_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_W(WE_W), .RD_CLKS(RD_CLKS)) i_bus (
    .clk(clk), .rst_n(srst_n), .start(b_start), .rd(b_rd),
    .addr_i(b_addr), .data_i(b_data), .we_clks(cfg_we_clks),
    .done(b_done), .rdata(b_rdata),
    .ce_n(flash_ce_n), .oe_n(flash_oe_n), .we_n(flash_we_n),
    .addr_o(flash_addr), .dq_out(flash_dq_out), .dq_oe(flash_dq_oe),
    .dq_in(flash_dq_in)
  );

  assign req_ready     = (st_q == T_IDLE);
  assign done_valid    = (st_q == T_DONE);
  assign done_timeout  = done_valid && tmo_q;
  assign done_mismatch = done_valid && mis_q;

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              flash_we_n,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_dq_out,
  input logic              flash_dq_oe,
  input logic              done_valid,
  input logic              done_timeout,
  input logic              done_mismatch
);

  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> req_ready);

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_we_n && flash_oe_n));

  a_r4_we_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n && flash_dq_oe));

  a_r4_setup_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> ($past(flash_dq_oe) && $stable(flash_addr) && $stable(flash_dq_out)));

  a_r4_steady_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

  a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (flash_dq_oe && !flash_ce_n && $stable(flash_dq_out) && $stable(flash_addr)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> (!flash_dq_oe && flash_we_n && !flash_ce_n));

  a_r5_gap_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_oe_n) |-> ($past(flash_we_n) && !$past(flash_dq_oe)));

  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |-> (!done_timeout && !done_mismatch));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout |-> !done_mismatch);

endmodule

bind fpc_top fpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
  .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
  .done_valid(done_valid), .done_timeout(done_timeout), .done_mismatch(done_mismatch)
);

// File: tb/test_fpc_top.sv
module test_fpc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_erase = 1'b0;
  logic        req_toggle = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [3:0]  cfg_we_clks = 4'd2;
  logic [15:0] cfg_poll_limit = 16'd20;
  logic        flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe;
  logic [17:0] flash_addr;
  logic [7:0]  flash_dq_out, flash_dq_in;
  logic        done_valid, done_timeout, done_mismatch;

  always #5 clk = ~clk;

  fpc_top i_fpc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .cfg_we_clks(cfg_we_clks), .cfg_poll_limit(cfg_poll_limit),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .done_valid(done_valid), .done_timeout(done_timeout),
    .done_mismatch(done_mismatch)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [17:0] a; logic [7:0] d; string tag; } wr_t;
  typedef struct { bit tmo; bit mis; string tag; } res_t;
  wr_t  wq[$];
  res_t rq[$];

  // device model state
  logic [7:0]  mem [int];
  logic [7:0]  rd_val = 8'h00;
  int          busy_reads = 0;
  bit          busy = 0, busy_erase = 0, tog = 0;
  logic [17:0] busy_addr;
  logic [7:0]  busy_data;
  int          step = 0;
  int          rd_cnt = 0;
  int          abort_cnt = 0, abort_seen = 0;
  bit          prev_we = 1, prev_oe = 1, prev_dqoe = 0;
  int          we_low = 0;
  logic [17:0] fall_addr;
  int          res_seen = 0;
  bit          after_done = 0;

  assign flash_dq_in = (!flash_oe_n && !flash_ce_n) ? rd_val : 8'h00;

  function automatic logic [7:0] mem_rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
  endfunction

  task automatic wr_event(input logic [17:0] a, input logic [7:0] d);
    int expw;
    expw = (cfg_we_clks == 4'd0) ? 1 : int'(cfg_we_clks);
    chk(we_low == expw, "R4", "write-enable low width", we_low, expw);
    chk(fall_addr == a, "R4", "address changed while strobe low", a, fall_addr);
    if (wq.size() == 0) begin
      chk(1'b0, "R2", "unexpected write cycle", a, 0);
    end else begin
      wr_t e;
      e = wq.pop_front();
      chk(e.a == a && e.d == d, e.tag, "write cycle (addr,data)",
          {a, d}, {e.a, e.d});
    end
    if (!busy) begin
      case (step)
        0: step = (a == 18'h05555 && d == 8'hAA) ? 1 : 0;
        1: step = (a == 18'h02AAA && d == 8'h55) ? 2 : 0;
        2: step = (a == 18'h05555 && d == 8'hA0) ? 10 :
                  (a == 18'h05555 && d == 8'h80) ? 3 : 0;
        3: step = (a == 18'h05555 && d == 8'hAA) ? 4 : 0;
        4: step = (a == 18'h02AAA && d == 8'h55) ? 5 : 0;
        5: begin
          if (a == 18'h05555 && d == 8'h10) begin
            busy = 1; busy_erase = 1; tog = 0; busy_addr = a;
            busy_data = 8'hFF;
          end
          step = 0;
        end
        10: begin
          busy = 1; busy_erase = 0; tog = 0; busy_addr = a; busy_data = d;
          step = 0;
        end
        default: step = 0;
      endcase
    end
  endtask

  task automatic rd_event();
    chk(!flash_dq_oe && flash_we_n && prev_we && !prev_dqoe, "R5",
        "read framing (dq_oe, we_n, previous cycle)",
        {flash_dq_oe, flash_we_n, prev_we, prev_dqoe}, 4'b0110);
    rd_cnt++;
    if (busy && busy_reads > 0) begin
      busy_reads--;
      rd_val = busy_erase ? {1'b0, tog, 6'h3F} : {~busy_data[7], tog, busy_data[5:0]};
      tog = ~tog;
    end else begin
      if (busy) begin
        if (busy_erase) mem.delete();
        else mem[int'(busy_addr)] = mem_rd(busy_addr) & busy_data;
        busy = 0;
      end
      rd_val = mem_rd(flash_addr);
    end
  endtask

  always @(negedge clk) begin
    if (abort_cnt != abort_seen) begin
      abort_seen = abort_cnt;
      busy = 0;
      step = 0;
    end
    if (prev_we && !flash_we_n) begin
      fall_addr = flash_addr;
      we_low = 1;
    end else if (!flash_we_n) begin
      we_low++;
    end
    if (!prev_we && flash_we_n) wr_event(flash_addr, flash_dq_out);
    if (prev_oe && !flash_oe_n) rd_event();
    prev_we   = flash_we_n;
    prev_oe   = flash_oe_n;
    prev_dqoe = flash_dq_oe;
  end

  // result monitor
  always @(negedge clk) begin
    if (after_done) begin
      after_done = 0;
      chk(req_ready && !done_timeout && !done_mismatch && !done_valid, "R10",
          "flags/ready in cycle after done",
          {req_ready, done_timeout, done_mismatch, done_valid}, 4'b1000);
    end
    if (done_valid) begin
      if (rq.size() == 0) begin
        chk(1'b0, "R1", "unexpected done", 1, 0);
      end else begin
        res_t r;
        r = rq.pop_front();
        chk(done_timeout == r.tmo && done_mismatch == r.mis, r.tag,
            "result flags (timeout,mismatch)",
            {done_timeout, done_mismatch}, {r.tmo, r.mis});
      end
      after_done = 1;
      res_seen++;
    end
  end

  task automatic run_op(input bit er, input bit tg, input logic [17:0] a,
                        input logic [7:0] d, input int busy_n, input logic [3:0] wclk,
                        input logic [15:0] lim, input bit e_tmo, input bit e_mis,
                        input string rtag, input int e_reads);
    int rd0, res0;
    string wtag;
    wtag = er ? "R3" : "R2";
    if (er) begin
      wq.push_back('{18'h05555, 8'hAA, wtag});
      wq.push_back('{18'h02AAA, 8'h55, wtag});
      wq.push_back('{18'h05555, 8'h80, wtag});
      wq.push_back('{18'h05555, 8'hAA, wtag});
      wq.push_back('{18'h02AAA, 8'h55, wtag});
      wq.push_back('{18'h05555, 8'h10, wtag});
    end else begin
      wq.push_back('{18'h05555, 8'hAA, wtag});
      wq.push_back('{18'h02AAA, 8'h55, wtag});
      wq.push_back('{18'h05555, 8'hA0, wtag});
      wq.push_back('{a, d, wtag});
    end
    rq.push_back('{e_tmo, e_mis, rtag});
    @(negedge clk);
    busy_reads     = busy_n;
    cfg_we_clks    = wclk;
    cfg_poll_limit = lim;
    rd0  = rd_cnt;
    res0 = res_seen;
    req_valid = 1'b1; req_erase = er; req_toggle = tg; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready low while operation runs", req_ready, 0);
    while (res_seen == res0) @(negedge clk);
    chk(wq.size() == 0, wtag, "write cycles left unissued", wq.size(), 0);
    if (e_reads >= 0)
      chk(rd_cnt - rd0 == e_reads, rtag, "number of read cycles", rd_cnt - rd0, e_reads);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !done_valid,
        "R1", "reset state",
        {req_ready, flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, done_valid}, 6'b111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R6: program, data polling, 3 busy reads -> 4 polls + verify
    run_op(0, 0, 18'h12345, 8'h5A, 3, 4'd2, 16'd20, 0, 0, "R6", 5);
    // R7: program, toggle polling
    run_op(0, 1, 18'h00010, 8'hC3, 4, 4'd1, 16'd20, 0, 0, "R7", -1);
    // R3/R6: erase, data polling, 5 busy reads; verify at 12345 reads FF
    run_op(1, 0, 18'h12345, 8'h00, 5, 4'd3, 16'd20, 0, 0, "R6", 7);
    // R3/R7: erase, toggle polling
    run_op(1, 1, 18'h00777, 8'h00, 2, 4'd2, 16'd20, 0, 0, "R7", -1);
    // R8: prepare FE, then request 01 (needs 0->1) -> stored 00, mismatch
    run_op(0, 0, 18'h00400, 8'hFE, 0, 4'd2, 16'd20, 0, 0, "R6", 2);
    run_op(0, 0, 18'h00400, 8'h01, 2, 4'd2, 16'd20, 0, 1, "R8", 4);
    // R9: device stuck, data polling, limit 6 -> 6 reads, timeout
    run_op(0, 0, 18'h00020, 8'h33, 1000, 4'd2, 16'd6, 1, 0, "R9", 6);
    abort_cnt++;
    @(negedge clk);
    // R9: completion on the last permitted read wins over the limit
    run_op(0, 0, 18'h00030, 8'h44, 3, 4'd2, 16'd4, 0, 0, "R9", 5);
    // R9: device stuck, toggle polling, limit 5
    run_op(0, 1, 18'h00040, 8'h55, 1000, 4'd2, 16'd5, 1, 0, "R9", 5);
    abort_cnt++;
    @(negedge clk);
    // R4: strobe width setting 0 behaves as 1
    run_op(0, 0, 18'h00050, 8'h66, 1, 4'd0, 16'd20, 0, 0, "R6", 3);
    // R4: wide strobe
    run_op(0, 0, 18'h00060, 8'h77, 1, 4'd9, 16'd20, 0, 0, "R6", 3);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule